// File: doc/BRIEF.md
# ADC Test-Pattern Substitution Generator

This block sits in the sample stream between the readout of a switched-capacitor array ADC and the packer that follows it. It follows the position of every incoming 12-bit ADC word inside a readout, tracking which row the word belongs to and which sample bin within that row. The position counters drive a deterministic test word, and that word replaces the ADC data when the pattern mode is selected. The downstream logic can then check its framing and ordering against known values with no analog signal present.

A readout begins with a one-cycle start pulse. The pulse clears the position to the first row and bin 0 and latches the mode selection for the whole readout. Each sample strobe after that produces one registered output word one cycle later. The strobe stream also advances the position. After the last bin of the last row, the block ignores further strobes until the next start pulse.

Top module: `adc_pattern_sub`

## Requirements
- R1: After reset, `out_valid_o` and `out_data_o` are 0, and strobes arriving before the first start pulse produce no output.
- R2: A strobe that is accepted at a clock edge makes `out_valid_o` high for exactly the following cycle, with its word on `out_data_o`. A cycle without an accepted strobe leaves `out_valid_o` low.
- R3: When the latched mode is pass-through, each accepted strobe's `smp_data_i` appears unchanged on `out_data_o`.
- R4: When the latched mode is pattern, `out_data_o[11:9]` carries the row field and `out_data_o[8:0]` carries the bin field. The ADC data is not used.
- R5: Rows are numbered 1 to 79. The row field is the low three bits of (row − 1), so row 1 gives 0 and row 79 gives 6, which is 78 modulo 8.
- R6: Bins are numbered 0 to 509. The bin field is (bin − 1) modulo 510, so bin 0 gives 509, bin 1 gives 0 and bin 509 gives 508.
- R7: Each accepted strobe advances the bin. After bin 509, the bin returns to 0 and the row increments.
- R8: After 79 × 510 accepted strobes, further strobes produce no output until the next start pulse.
- R9: `test_en_i` is sampled only in the start-pulse cycle, where 1 selects pattern mode. Changing it during a readout has no effect on that readout.
- R10: A start pulse restarts at row 1, bin 0 even in the middle of a readout. A strobe in the same cycle as the start pulse is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start-of-readout pulse |
| smp_valid_i | input | 1 | Sample strobe |
| smp_data_i | input | 12 | ADC sample word |
| test_en_i | input | 1 | Pattern mode request, latched at start |
| out_valid_o | output | 1 | Output word valid |
| out_data_o | output | 12 | Registered output word |

## Verification
On every cycle, the assertions check that an output appears only after a strobe, never after a start pulse and never while the block is idle. They also check that pass-through words equal the sampled input, that the bin field stays within range, and that consecutive pattern words step their bin field by one. Only the bench scenarios can show the exact row and bin values across a full readout. The same holds for the row rollover after bin 509, the stop after the last row, the insensitivity to mid-readout mode changes, and the restart value after a start pulse in the middle of a readout.

// File: rtl/adc_pat_pkg.sv
package adc_pat_pkg;
   typedef enum logic {
      MODE_PASS    = 1'b0,
      MODE_PATTERN = 1'b1
   } pat_mode_e;

   localparam int unsigned DEF_DATA_W = 12;
   localparam int unsigned DEF_ROWS   = 79;
   localparam int unsigned DEF_BINS   = 510;
   localparam int unsigned DEF_RF_W   = 3;
   localparam int unsigned DEF_BF_W   = 9;
endpackage

// File: rtl/adc_pat_tracker.sv
module adc_pat_tracker
   import adc_pat_pkg::*;
#(
   parameter int unsigned ROWS  = DEF_ROWS,
   parameter int unsigned BINS  = DEF_BINS,
   parameter int unsigned ROW_W = $clog2(ROWS + 1),
   parameter int unsigned BIN_W = $clog2(BINS)
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             start_i,
   input  logic             smp_valid_i,
   input  logic             test_en_i,
   output logic             accept_o,
   output logic [ROW_W-1:0] row_o,
   output logic [BIN_W-1:0] bin_o,
   output pat_mode_e        mode_o,
   output logic             idle_o
);
   localparam logic [ROW_W-1:0] ROW_FIRST = ROW_W'(1);
   localparam logic [ROW_W-1:0] ROW_LAST  = ROW_W'(ROWS);
   localparam logic [BIN_W-1:0] BIN_LAST  = BIN_W'(BINS - 1);

   logic [ROW_W-1:0] row_q;
   logic [BIN_W-1:0] bin_q;
   logic             idle_q;
   pat_mode_e        mode_q;

   // a start pulse always wins over a strobe in the same cycle
   assign accept_o = smp_valid_i && !start_i && !idle_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         row_q  <= ROW_FIRST;
         bin_q  <= '0;
         idle_q <= 1'b1;
         mode_q <= MODE_PASS;
      end else if (start_i) begin
         row_q  <= ROW_FIRST;
         bin_q  <= '0;
         idle_q <= 1'b0;
         mode_q <= test_en_i ? MODE_PATTERN : MODE_PASS;
      end else if (accept_o) begin
         if (bin_q == BIN_LAST) begin
            bin_q <= '0;
            if (row_q == ROW_LAST) idle_q <= 1'b1;
            else                   row_q  <= row_q + ROW_W'(1);
         end else begin
            bin_q <= bin_q + BIN_W'(1);
         end
      end
   end

   assign row_o  = row_q;
   assign bin_o  = bin_q;
   assign mode_o = mode_q;
   assign idle_o = idle_q;
endmodule

// File: rtl/adc_pat_format.sv
module adc_pat_format
   import adc_pat_pkg::*;
#(
   parameter int unsigned DATA_W = DEF_DATA_W,
   parameter int unsigned BINS   = DEF_BINS,
   parameter int unsigned RF_W   = DEF_RF_W,
   parameter int unsigned BF_W   = DEF_BF_W,
   parameter int unsigned ROW_W  = 7,
   parameter int unsigned BIN_W  = $clog2(BINS)
) (
   input  logic [ROW_W-1:0]  row_i,
   input  logic [BIN_W-1:0]  bin_i,
   input  pat_mode_e         mode_i,
   input  logic [DATA_W-1:0] data_i,
   output logic [DATA_W-1:0] word_o
);
   logic [RF_W-1:0] row_field;
   logic [BF_W-1:0] bin_field;

   // row numbering starts at 1; the field reports the index minus one
   assign row_field = RF_W'(row_i) - RF_W'(1);

   generate
      if (BINS == (1 << BF_W)) begin : g_wrap_free
         assign bin_field = BF_W'(bin_i) - BF_W'(1);
      end else begin : g_wrap_cmp
         assign bin_field = (bin_i == '0) ? BF_W'(BINS - 1)
                                          : BF_W'(bin_i) - BF_W'(1);
      end
   endgenerate

   assign word_o = (mode_i == MODE_PATTERN) ? {row_field, bin_field} : data_i;
endmodule

// File: rtl/adc_pat_outreg.sv
module adc_pat_outreg #(
   parameter int unsigned DATA_W = 12
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              load_i,
   input  logic [DATA_W-1:0] word_i,
   output logic              valid_o,
   output logic [DATA_W-1:0] word_o
);
   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         valid_o <= 1'b0;
         word_o  <= '0;
      end else begin
         valid_o <= load_i;
         if (load_i) word_o <= word_i;
      end
   end
endmodule

// File: rtl/adc_pattern_sub.sv
module adc_pattern_sub
   import adc_pat_pkg::*;
#(
   parameter int unsigned DATA_W = DEF_DATA_W,
   parameter int unsigned ROWS   = DEF_ROWS,
   parameter int unsigned BINS   = DEF_BINS,
   parameter int unsigned RF_W   = DEF_RF_W,
   parameter int unsigned BF_W   = DEF_BF_W
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              start_i,
   input  logic              smp_valid_i,
   input  logic [DATA_W-1:0] smp_data_i,
   input  logic              test_en_i,
   output logic              out_valid_o,
   output logic [DATA_W-1:0] out_data_o
);
   localparam int unsigned ROW_W = $clog2(ROWS + 1);
   localparam int unsigned BIN_W = $clog2(BINS);

   generate
      if (RF_W + BF_W != DATA_W) begin : g_bad_split
         $error("row and bin field widths must fill the data word");
      end
      if (BINS < 2 || BINS > (1 << BF_W)) begin : g_bad_bins
         $error("bin count must fit the bin field");
      end
      if (ROWS < 1 || ROW_W < RF_W) begin : g_bad_rows
         $error("row count too small for the row field");
      end
   endgenerate

   logic             accept;
   logic [ROW_W-1:0] trk_row;
   logic [BIN_W-1:0] trk_bin;
   pat_mode_e        trk_mode;
   logic             trk_idle;
   logic             pat_on;
   logic [DATA_W-1:0] sel_word;

   assign pat_on = (trk_mode == MODE_PATTERN);

   adc_pat_tracker #(
      .ROWS(ROWS), .BINS(BINS), .ROW_W(ROW_W), .BIN_W(BIN_W)
   ) u_trk (
      .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
      .smp_valid_i(smp_valid_i), .test_en_i(test_en_i),
      .accept_o(accept), .row_o(trk_row), .bin_o(trk_bin),
      .mode_o(trk_mode), .idle_o(trk_idle)
   );

   adc_pat_format #(
      .DATA_W(DATA_W), .BINS(BINS), .RF_W(RF_W), .BF_W(BF_W),
      .ROW_W(ROW_W), .BIN_W(BIN_W)
   ) u_fmt (
      .row_i(trk_row), .bin_i(trk_bin), .mode_i(trk_mode),
      .data_i(smp_data_i), .word_o(sel_word)
   );

   adc_pat_outreg #(
      .DATA_W(DATA_W)
   ) u_out (
      .clk_i(clk_i), .rst_ni(rst_ni), .load_i(accept), .word_i(sel_word),
      .valid_o(out_valid_o), .word_o(out_data_o)
   );
endmodule

// File: rtl/adc_pattern_sub_chk.sv
module adc_pattern_sub_chk #(
   parameter int unsigned DATA_W = 12,
   parameter int unsigned BINS   = 510,
   parameter int unsigned BF_W   = 9
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_i,
   input logic              smp_valid_i,
   input logic [DATA_W-1:0] smp_data_i,
   input logic              out_valid_o,
   input logic [DATA_W-1:0] out_data_o,
   input logic              pat_on,
   input logic              idle
);
   // R2: no output without a strobe one cycle earlier
   p_no_spurious_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(smp_valid_i) |-> !out_valid_o);

   // R10: a strobe coinciding with start is dropped
   p_start_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $past(start_i) |-> !out_valid_o);

   // R8: idle tracker emits nothing
   p_idle_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
      idle && !start_i |=> !out_valid_o);

   // R3: pass-through words equal the sampled input
   p_pass_equal_r3: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid_o && !pat_on |-> out_data_o == $past(smp_data_i));

   // R6: bin field never exceeds the last bin value
   p_bin_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid_o && pat_on |-> out_data_o[BF_W-1:0] <= BF_W'(BINS - 1));

   // R7: back-to-back pattern words advance the bin field by one
   p_bin_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid_o && $past(out_valid_o) && pat_on && $past(pat_on)
      && ($past(out_data_o[BF_W-1:0]) != BF_W'(BINS - 1))
      |-> out_data_o[BF_W-1:0] == BF_W'($past(out_data_o[BF_W-1:0]) + 1'b1));
endmodule

bind adc_pattern_sub adc_pattern_sub_chk #(
   .DATA_W(DATA_W), .BINS(BINS), .BF_W(BF_W)
) u_chk (
   .clk(clk_i), .rst_n(rst_ni), .start_i(start_i),
   .smp_valid_i(smp_valid_i), .smp_data_i(smp_data_i),
   .out_valid_o(out_valid_o), .out_data_o(out_data_o),
   .pat_on(pat_on), .idle(trk_idle)
);

// File: tb/adc_pattern_sub_test.sv
module adc_pattern_sub_test;
   localparam int ROWS = 79;
   localparam int BINS = 510;

   logic        clk = 1'b0;
   logic        rst_n, start_i, smp_valid_i, test_en_i;
   logic [11:0] smp_data_i;
   logic        out_valid_o;
   logic [11:0] out_data_o;

   always #5 clk = ~clk;

   adc_pattern_sub uut (
      .clk_i(clk), .rst_ni(rst_n), .start_i(start_i),
      .smp_valid_i(smp_valid_i), .smp_data_i(smp_data_i),
      .test_en_i(test_en_i), .out_valid_o(out_valid_o),
      .out_data_o(out_data_o)
   );

   int          n_chk = 0;
   int          n_fail = 0;
   logic [11:0] exp_q[$];
   string       tag_q[$];
   string       unexp_tag = "R1";
   string       cur_tag = "";
   int          m_row = 1;
   int          m_bin = 0;
   bit          m_idle = 1'b1;
   bit          m_pat = 1'b0;
   logic [11:0] mon_exp;
   string       mon_tag;

   task automatic chk(input bit ok, input string tag,
                      input logic [11:0] act, input logic [11:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // driver: applies one cycle of stimulus and records the expected output
   task automatic cyc(input bit st, input bit v, input logic [11:0] d);
      logic [2:0]  rf;
      logic [8:0]  bf;
      logic [11:0] e;
      string       t;
      start_i     = st;
      smp_valid_i = v;
      smp_data_i  = d;
      if (st) begin
         m_row = 1; m_bin = 0; m_idle = 1'b0; m_pat = test_en_i;
      end else if (v && !m_idle) begin
         if (m_pat) begin
            rf = 3'((m_row - 1) % 8);
            bf = 9'((m_bin == 0) ? BINS - 1 : m_bin - 1);
            e  = {rf, bf};
            if (m_bin == 0 && m_row > 1)          t = "R7";
            else if (m_bin == 0 || m_bin == BINS - 1) t = "R6";
            else if (m_row == ROWS)               t = "R5";
            else                                  t = "R4";
         end else begin
            e = d;
            t = "R3";
         end
         if (cur_tag != "") t = cur_tag;
         exp_q.push_back(e);
         tag_q.push_back(t);
         if (m_bin == BINS - 1) begin
            m_bin = 0;
            if (m_row == ROWS) m_idle = 1'b1;
            else               m_row++;
         end else begin
            m_bin++;
         end
      end
      @(negedge clk);
   endtask

   task automatic drain(input string tag);
      cyc(1'b0, 1'b0, 12'h000);
      cyc(1'b0, 1'b0, 12'h000);
      chk(exp_q.size() == 0, tag, 12'(exp_q.size()), 12'h000);
   endtask

   // monitor: compares every valid output with the scoreboard head
   always @(negedge clk) begin
      if (rst_n === 1'b1 && out_valid_o === 1'b1) begin
         if (exp_q.size() == 0) begin
            chk(1'b0, unexp_tag, out_data_o, 12'h000);
         end else begin
            mon_exp = exp_q.pop_front();
            mon_tag = tag_q.pop_front();
            chk(out_data_o === mon_exp, mon_tag, out_data_o, mon_exp);
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

   initial begin
      rst_n = 1'b0; start_i = 1'b0; smp_valid_i = 1'b0;
      smp_data_i = '0; test_en_i = 1'b0;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(out_valid_o === 1'b0, "R1", {11'h0, out_valid_o}, 12'h000);
      chk(out_data_o === 12'h000, "R1", out_data_o, 12'h000);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: strobes before any start are ignored
      unexp_tag = "R1";
      for (int i = 0; i < 5; i++) cyc(1'b0, 1'b1, 12'hF00 + 12'(i));
      drain("R1");

      // R2: one-cycle latency, single pulse of valid
      test_en_i = 1'b0;
      unexp_tag = "R2";
      cyc(1'b1, 1'b0, 12'h000);
      cyc(1'b0, 1'b1, 12'h123);
      chk(out_valid_o === 1'b1, "R2", {11'h0, out_valid_o}, 12'h001);
      chk(out_data_o === 12'h123, "R2", out_data_o, 12'h123);
      cyc(1'b0, 1'b0, 12'h000);
      chk(out_valid_o === 1'b0, "R2", {11'h0, out_valid_o}, 12'h000);

      // R3: pass-through with gaps in the strobe stream
      for (int i = 0; i < 24; i++)
         cyc(1'b0, (i % 3) != 2, 12'(i * 173) ^ 12'hA5A);
      drain("R3");

      // R9: mode change mid readout is ignored (pass-through latched)
      cyc(1'b1, 1'b0, 12'h000);
      test_en_i = 1'b1;
      cur_tag = "R9";
      for (int i = 0; i < 6; i++) cyc(1'b0, 1'b1, 12'h3C0 + 12'(i));
      // R9: pattern latched, request dropped mid readout
      cyc(1'b1, 1'b0, 12'h000);
      test_en_i = 1'b0;
      for (int i = 0; i < 6; i++) cyc(1'b0, 1'b1, 12'h777);
      cur_tag = "";
      drain("R9");

      // R10: strobe with start is dropped; mid-readout restart
      test_en_i = 1'b1;
      unexp_tag = "R10";
      cyc(1'b1, 1'b1, 12'hBAD);
      cyc(1'b0, 1'b1, 12'h000);
      chk(out_data_o === 12'h1FD, "R10", out_data_o, 12'h1FD);
      for (int i = 0; i < 7; i++) cyc(1'b0, 1'b1, 12'h000);
      cyc(1'b1, 1'b0, 12'h000);
      cyc(1'b0, 1'b1, 12'h000);
      chk(out_data_o === 12'h1FD, "R10", out_data_o, 12'h1FD);
      drain("R10");

      // R4 R5 R6 R7: full pattern readout
      unexp_tag = "R7";
      cyc(1'b1, 1'b0, 12'h000);
      for (int i = 0; i < ROWS * BINS; i++) begin
         cyc(1'b0, 1'b1, 12'(i));
         if (i == 0)
            chk(out_data_o === 12'h1FD, "R6", out_data_o, 12'h1FD);
         if (i == 1)
            chk(out_data_o === 12'h000, "R6", out_data_o, 12'h000);
         if (i == BINS)
            chk(out_data_o === 12'h3FD, "R7", out_data_o, 12'h3FD);
         if (i == ROWS * BINS - 1)
            chk(out_data_o === 12'hDFC, "R5", out_data_o, 12'hDFC);
      end
      drain("R5");

      // R8: strobes after the last row produce nothing
      unexp_tag = "R8";
      for (int i = 0; i < 8; i++) cyc(1'b0, 1'b1, 12'h0F0);
      drain("R8");

      // R10: new start re-arms after completion
      unexp_tag = "R10";
      cyc(1'b1, 1'b0, 12'h000);
      cyc(1'b0, 1'b1, 12'h000);
      chk(out_data_o === 12'h1FD, "R10", out_data_o, 12'h1FD);
      drain("R10");

      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end
endmodule